// File: doc/BRIEF.md
# Remappable Memory Address Decoder

This block sits on a 32-bit little-endian system bus and turns each access into a select for one of three targets: the on-chip SRAM, the on-chip flash, or the memory-mapped register block. Along with the select it returns the local byte offset within that target and the four byte-lane enables. Any access it cannot route raises a bus error instead of a select. The error cases are an unmapped address, a misaligned or illegal size, and a write into the protected boot page.

The lowest 64 KB of the address space is an alias window. A one-bit remap register decides which memory this window mirrors. The register lives inside the register block and is written over the same bus. After reset the window shows flash, so that code can start from address zero. Clearing the bit swaps the 8 KB SRAM into the window, and the SRAM image then repeats every 8 KB across it. The top 2 KB of flash is a boot page. The decoder refuses writes to it whether they arrive at the flash address itself or through the alias.

All outputs are registered. The result for an access presented in one cycle appears after the next rising clock edge. A write to the remap register takes effect for accesses decoded after that edge.

Top module: `memmap_decoder`

## Requirements
- R1: After reset all selects, lanes, offset and error are 0, and the remap bit is 1, so a read at address 0x00000004 selects flash with offset 0x0004.
- R2: An access in 0x00010000..0x00011FFF selects SRAM with offset equal to address bits [12:0].
- R3: An access in 0x00080000..0x0008FFFF selects flash with offset equal to address bits [15:0].
- R4: An access in 0xFFFF0000..0xFFFFFFFF selects the register block with offset equal to address bits [15:0].
- R5: With the remap bit at 1, an access in 0x00000000..0x0000FFFF selects flash with offset equal to address bits [15:0].
- R6: With the remap bit at 0, an access in 0x00000000..0x0000FFFF selects SRAM with offset equal to address bits [12:0], so the SRAM image repeats every 8 KB.
- R7: The remap bit is at register-block offset 0x0220. It loads write-data bit 0 on an error-free write that enables byte lane 0 there. Other data bits, writes to other offsets, and byte writes to lanes 1 to 3 leave it unchanged.
- R8: Size encoding is 0 = byte, 1 = halfword, 2 = word. The lane enables (bit n = byte n, little-endian) are 1<<addr[1:0] for a byte, 4'b0011 or 4'b1100 for a halfword at addr[1] = 0 or 1, and 4'b1111 for a word.
- R9: A halfword with addr[0] = 1, a word with addr[1:0] != 0, or size code 3 gives bus error 1, no select and lanes 0.
- R10: An access outside every region gives bus error 1 for that access's result cycle, no select and lanes 0. At most one select is ever high.
- R11: A write to flash offsets 0xF800..0xFFFF gives bus error 1 and no select. This holds for writes at the flash address and for writes through the alias while remap is 1. Reads there are allowed.
- R12: A cycle with neither read nor write strobe gives all selects, lanes, offset and error at 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, lane-aligned |
| sel_sram | output | 1 | SRAM select |
| sel_flash | output | 1 | Flash select |
| sel_mmr | output | 1 | Register-block select |
| loc_ofs | output | 16 | Byte offset inside the selected target |
| lane_en | output | 4 | Byte-lane enables |
| bus_err | output | 1 | Access rejected |

## Verification
The bench builds the decoder with its default parameters: an 8 KB SRAM at 0x00010000, a 64 KB flash at 0x00080000 with a 2 KB boot page, a 64 KB alias window and the register block at 0xFFFF0000. With these sizes, the last SRAM and flash bytes, the first unmapped byte after each region and the edge of the boot page are all single directed accesses. The 8-to-1 repetition of SRAM inside the alias window shows up as a small address difference. The remap bit is toggled both ways through the register block, and ignored writes near it are also exercised.

// File: rtl/memmap_pkg.sv
// Shared types for the remappable memory address decoder.
// Assumes a 32-bit byte-addressed little-endian bus with four byte lanes.
package memmap_pkg;

    // Access size code carried on the bus
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    // Decoded destination of one access
    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_SRAM  = 2'd1,
        TGT_FLASH = 2'd2,
        TGT_MMR   = 2'd3
    } target_e;

endpackage

// File: rtl/memmap_lanes.sv
// Byte-lane generator: turns size and low address bits into four lane
// enables (lane n carries byte address n mod 4) and flags accesses whose
// address is not a multiple of their size, or whose size code is illegal.
// Assumes a four-lane bus; purely combinational.
module memmap_lanes
    import memmap_pkg::*;
(
    input  logic [1:0] size,
    input  logic [1:0] a_lo,
    output logic [3:0] lanes,
    output logic       misalign
);

    // Decode lane enables and alignment fault for each size
    always_comb begin
        lanes    = 4'b0000;
        misalign = 1'b0;
        case (acc_size_e'(size))
            SZ_BYTE: lanes = 4'b0001 << a_lo;
            SZ_HALF: begin
                misalign = a_lo[0];
                lanes    = a_lo[1] ? 4'b1100 : 4'b0011;
            end
            SZ_WORD: begin
                misalign = |a_lo;
                lanes    = 4'b1111;
            end
            default: misalign = 1'b1;
        endcase
    end

endmodule

// File: rtl/memmap_region.sv
// Region decoder: maps a 32-bit address to SRAM, flash, register block or
// nothing, and produces the local offset. The alias window at address zero
// mirrors flash when remap is 1 and SRAM (repeating) when remap is 0.
// Reports whether the flash offset falls in the protected boot page.
// Assumes power-of-two region sizes and bases aligned to their size.
module memmap_region
    import memmap_pkg::*;
#(
    parameter logic [31:0] SRAM_BASE   = 32'h0001_0000,
    parameter int unsigned SRAM_BYTES  = 8192,
    parameter logic [31:0] FLASH_BASE  = 32'h0008_0000,
    parameter int unsigned FLASH_BYTES = 65536,
    parameter int unsigned BOOT_BYTES  = 2048,
    parameter logic [31:0] MMR_BASE    = 32'hFFFF_0000,
    parameter int unsigned MMR_BYTES   = 65536,
    parameter int unsigned ALIAS_BYTES = 65536,
    parameter int unsigned OFS_W       = 16
)(
    input  logic [31:0]      addr,
    input  logic             remap,
    output target_e          tgt,
    output logic [OFS_W-1:0] ofs,
    output logic             boot_hit
);

    localparam int unsigned SRAM_AW   = $clog2(SRAM_BYTES);
    localparam int unsigned FLASH_AW  = $clog2(FLASH_BYTES);
    localparam int unsigned MMR_AW    = $clog2(MMR_BYTES);
    localparam int unsigned BOOT_LOW  = FLASH_BYTES - BOOT_BYTES;

    logic in_alias, in_sram, in_flash, in_mmr;
    logic [OFS_W-1:0] sram_ofs, flash_ofs, mmr_ofs;

    // Region hits by unsigned distance from each base (handles top-of-space wrap)
    assign in_alias = addr < 32'(ALIAS_BYTES);
    assign in_sram  = (addr - SRAM_BASE)  < 32'(SRAM_BYTES);
    assign in_flash = (addr - FLASH_BASE) < 32'(FLASH_BYTES);
    assign in_mmr   = (addr - MMR_BASE)   < 32'(MMR_BYTES);

    // Local offsets: low address bits of each target, zero-extended
    assign sram_ofs  = OFS_W'(addr[SRAM_AW-1:0]);
    assign flash_ofs = OFS_W'(addr[FLASH_AW-1:0]);
    assign mmr_ofs   = OFS_W'(addr[MMR_AW-1:0]);

    // Pick the target and its offset; the alias follows the remap bit
    always_comb begin
        tgt = TGT_NONE;
        ofs = '0;
        if (in_alias) begin
            tgt = remap ? TGT_FLASH : TGT_SRAM;
            ofs = remap ? flash_ofs : sram_ofs;
        end else if (in_sram) begin
            tgt = TGT_SRAM;
            ofs = sram_ofs;
        end else if (in_flash) begin
            tgt = TGT_FLASH;
            ofs = flash_ofs;
        end else if (in_mmr) begin
            tgt = TGT_MMR;
            ofs = mmr_ofs;
        end
    end

    // Boot page: upper flash offsets, reached directly or through the alias
    assign boot_hit = (tgt == TGT_FLASH) && (flash_ofs >= OFS_W'(BOOT_LOW));

endmodule

// File: rtl/memmap_remap_reg.sv
// One-bit remap control register. Resets to 1 (flash at address zero).
// Loads write-data bit 0 when the decoder qualifies a write to it.
// Assumes the caller has already checked target, offset, lane and faults.
module memmap_remap_reg (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_hit,
    input  logic [31:0] wdata,
    output logic        remap
);

    logic unused_wdata;
    assign unused_wdata = ^wdata[31:1];

    // Hold the remap bit; only bit 0 of the data is stored
    always_ff @(posedge clk) begin
        if (!rst_n)      remap <= 1'b1;
        else if (wr_hit) remap <= wdata[0];
    end

endmodule

// File: rtl/memmap_decoder.sv
// Remappable memory address decoder, top level. Decodes each bus access
// into one target select, a local offset and byte-lane enables, all
// registered one cycle after the access. Faults (unmapped, misaligned,
// boot-page write) raise bus_err with no select. Hosts the remap register
// inside the register block at offset REMAP_OFS.
// Assumes at most one access per cycle and lane-aligned write data.
module memmap_decoder
    import memmap_pkg::*;
#(
    parameter logic [31:0] SRAM_BASE   = 32'h0001_0000,
    parameter int unsigned SRAM_BYTES  = 8192,
    parameter logic [31:0] FLASH_BASE  = 32'h0008_0000,
    parameter int unsigned FLASH_BYTES = 65536,
    parameter int unsigned BOOT_BYTES  = 2048,
    parameter logic [31:0] MMR_BASE    = 32'hFFFF_0000,
    parameter int unsigned MMR_BYTES   = 65536,
    parameter int unsigned ALIAS_BYTES = 65536,
    parameter int unsigned REMAP_OFS   = 32'h0220,
    localparam int unsigned OFS_W = $clog2(
        (FLASH_BYTES > MMR_BYTES) ?
            ((FLASH_BYTES > SRAM_BYTES) ? FLASH_BYTES : SRAM_BYTES) :
            ((MMR_BYTES > SRAM_BYTES) ? MMR_BYTES : SRAM_BYTES))
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      bus_addr,
    input  logic [1:0]       bus_size,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [31:0]      bus_wdata,
    output logic             sel_sram,
    output logic             sel_flash,
    output logic             sel_mmr,
    output logic [OFS_W-1:0] loc_ofs,
    output logic [3:0]       lane_en,
    output logic             bus_err
);

    logic             remap;
    target_e          tgt;
    logic [OFS_W-1:0] ofs;
    logic             boot_hit;
    logic [3:0]       lanes;
    logic             misalign;
    logic             acc;
    logic             fault;
    logic             remap_hit;

    memmap_region #(
        .SRAM_BASE   (SRAM_BASE),
        .SRAM_BYTES  (SRAM_BYTES),
        .FLASH_BASE  (FLASH_BASE),
        .FLASH_BYTES (FLASH_BYTES),
        .BOOT_BYTES  (BOOT_BYTES),
        .MMR_BASE    (MMR_BASE),
        .MMR_BYTES   (MMR_BYTES),
        .ALIAS_BYTES (ALIAS_BYTES),
        .OFS_W       (OFS_W)
    ) u_region (
        .addr     (bus_addr),
        .remap    (remap),
        .tgt      (tgt),
        .ofs      (ofs),
        .boot_hit (boot_hit)
    );

    memmap_lanes u_lanes (
        .size     (bus_size),
        .a_lo     (bus_addr[1:0]),
        .lanes    (lanes),
        .misalign (misalign)
    );

    // Qualify the access and collect every reason to reject it
    assign acc   = bus_rd | bus_wr;
    assign fault = misalign | (tgt == TGT_NONE) | (bus_wr & boot_hit);

    // Remap register write: clean write to its offset that carries lane 0
    assign remap_hit = acc && bus_wr && !fault && (tgt == TGT_MMR) &&
                       (ofs == OFS_W'(REMAP_OFS)) && lanes[0];

    memmap_remap_reg u_remap (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (remap_hit),
        .wdata  (bus_wdata),
        .remap  (remap)
    );

    // Register the decode result; faults and idle cycles drive nothing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_sram  <= 1'b0;
            sel_flash <= 1'b0;
            sel_mmr   <= 1'b0;
            loc_ofs   <= '0;
            lane_en   <= 4'b0000;
            bus_err   <= 1'b0;
        end else begin
            sel_sram  <= acc && !fault && (tgt == TGT_SRAM);
            sel_flash <= acc && !fault && (tgt == TGT_FLASH);
            sel_mmr   <= acc && !fault && (tgt == TGT_MMR);
            loc_ofs   <= (acc && !fault) ? ofs : '0;
            lane_en   <= (acc && !fault) ? lanes : 4'b0000;
            bus_err   <= acc && fault;
        end
    end

endmodule

// File: rtl/memmap_decoder_chk.sv
// Assertion checker for memmap_decoder, attached with bind below.
// Observes only the top-level ports; parameters mirror the top's defaults.
module memmap_decoder_chk #(
    parameter logic [31:0] SRAM_BASE   = 32'h0001_0000,
    parameter int unsigned SRAM_BYTES  = 8192,
    parameter logic [31:0] FLASH_BASE  = 32'h0008_0000,
    parameter int unsigned FLASH_BYTES = 65536,
    parameter int unsigned BOOT_BYTES  = 2048,
    parameter logic [31:0] MMR_BASE    = 32'hFFFF_0000,
    parameter int unsigned OFS_W       = 16
)(
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      bus_addr,
    input logic [1:0]       bus_size,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic             sel_sram,
    input logic             sel_flash,
    input logic             sel_mmr,
    input logic [OFS_W-1:0] loc_ofs,
    input logic [3:0]       lane_en,
    input logic             bus_err
);

    logic acc;
    assign acc = bus_rd | bus_wr;

    // R10: never more than one target selected
    p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_sram, sel_flash, sel_mmr}));

    // R9: an error result carries no select and no lanes
    p_err_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> !(sel_sram || sel_flash || sel_mmr) && lane_en == 4'b0000);

    // R12: an idle cycle yields an idle result
    p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !bus_err && !(sel_sram || sel_flash || sel_mmr) && lane_en == 4'b0000);

    // R2: byte access in the direct SRAM range selects SRAM with low offset
    p_sram_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && bus_size == 2'd0 && (bus_addr - SRAM_BASE) < 32'(SRAM_BYTES))
        |=> sel_sram && loc_ofs == OFS_W'($past(bus_addr) & 32'(SRAM_BYTES - 1)));

    // R11: write to the boot page at its flash address is rejected
    p_boot_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr - FLASH_BASE) < 32'(FLASH_BYTES) &&
         (bus_addr - FLASH_BASE) >= 32'(FLASH_BYTES - BOOT_BYTES))
        |=> bus_err && !sel_flash);

    // R8: aligned word in the register block enables all four lanes
    p_word_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && bus_size == 2'd2 && bus_addr[1:0] == 2'b00 && bus_addr >= MMR_BASE)
        |=> sel_mmr && lane_en == 4'b1111);

endmodule

bind memmap_decoder memmap_decoder_chk #(
    .SRAM_BASE   (SRAM_BASE),
    .SRAM_BYTES  (SRAM_BYTES),
    .FLASH_BASE  (FLASH_BASE),
    .FLASH_BYTES (FLASH_BYTES),
    .BOOT_BYTES  (BOOT_BYTES),
    .MMR_BASE    (MMR_BASE),
    .OFS_W       (OFS_W)
) i_memmap_decoder_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .sel_sram  (sel_sram),
    .sel_flash (sel_flash),
    .sel_mmr   (sel_mmr),
    .loc_ofs   (loc_ofs),
    .lane_en   (lane_en),
    .bus_err   (bus_err)
);

// File: tb/test_memmap_decoder.sv
`timescale 1ns/1ps
// Directed bench for memmap_decoder: one task per scenario, each checking
// the registered result one clock after it drives an access.
module test_memmap_decoder;

    localparam logic [2:0] S_NONE  = 3'b000;  // {mmr, flash, sram}
    localparam logic [2:0] S_SRAM  = 3'b001;
    localparam logic [2:0] S_FLASH = 3'b010;
    localparam logic [2:0] S_MMR   = 3'b100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        sel_sram, sel_flash, sel_mmr;
    logic [15:0] loc_ofs;
    logic [3:0]  lane_en;
    logic        bus_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    memmap_decoder i_memmap_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .sel_sram  (sel_sram),
        .sel_flash (sel_flash),
        .sel_mmr   (sel_mmr),
        .loc_ofs   (loc_ofs),
        .lane_en   (lane_en),
        .bus_err   (bus_err)
    );

    // Compare the whole registered result against expectations
    task automatic expect_out(string req, logic [2:0] sel, logic [15:0] ofs,
                              logic [3:0] lanes, logic err);
        logic [2:0] act_sel;
        act_sel = {sel_mmr, sel_flash, sel_sram};
        checks++;
        if (act_sel !== sel || loc_ofs !== ofs || lane_en !== lanes || bus_err !== err) begin
            errors++;
            $display("FAIL %s: actual sel=%b ofs=%h lanes=%b err=%b expected sel=%b ofs=%h lanes=%b err=%b",
                     req, act_sel, loc_ofs, lane_en, bus_err, sel, ofs, lanes, err);
        end
    endtask

    // Drive one access at a falling edge; result is valid after the next rise
    task automatic access(logic [31:0] a, logic [1:0] sz, logic rd, logic wr, logic [31:0] wd);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
        @(posedge clk);
        #1;
    endtask

    task automatic idle_cycle();
        access(32'h0, 2'd0, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic t_reset();
        expect_out("R1 reset outputs", S_NONE, 16'h0, 4'h0, 1'b0);
        access(32'h0000_0004, 2'd2, 1'b1, 1'b0, 0);
        expect_out("R1 R5 alias is flash after reset", S_FLASH, 16'h0004, 4'hF, 1'b0);
        idle_cycle();
        expect_out("R12 idle", S_NONE, 16'h0, 4'h0, 1'b0);
    endtask

    task automatic t_sram();
        access(32'h0001_1FFE, 2'd1, 1'b1, 1'b0, 0);
        expect_out("R2 R8 sram top halfword", S_SRAM, 16'h1FFE, 4'b1100, 1'b0);
        access(32'h0001_0003, 2'd0, 1'b0, 1'b1, 0);
        expect_out("R2 R8 sram byte lane 3", S_SRAM, 16'h0003, 4'b1000, 1'b0);
        access(32'h0001_0001, 2'd0, 1'b1, 1'b0, 0);
        expect_out("R8 byte lane 1", S_SRAM, 16'h0001, 4'b0010, 1'b0);
        access(32'h0001_0100, 2'd1, 1'b1, 1'b0, 0);
        expect_out("R8 low halfword", S_SRAM, 16'h0100, 4'b0011, 1'b0);
    endtask

    task automatic t_flash_mmr();
        access(32'h0008_1234, 2'd2, 1'b1, 1'b0, 0);
        expect_out("R3 flash word", S_FLASH, 16'h1234, 4'hF, 1'b0);
        access(32'h0008_FFFC, 2'd2, 1'b1, 1'b0, 0);
        expect_out("R11 boot page readable", S_FLASH, 16'hFFFC, 4'hF, 1'b0);
        access(32'hFFFF_0010, 2'd2, 1'b1, 1'b0, 0);
        expect_out("R4 register block word", S_MMR, 16'h0010, 4'hF, 1'b0);
        access(32'hFFFF_FFFF, 2'd0, 1'b1, 1'b0, 0);
        expect_out("R4 register block last byte", S_MMR, 16'hFFFF, 4'b1000, 1'b0);
    endtask

    task automatic t_unmapped();
        access(32'h0001_2000, 2'd2, 1'b1, 1'b0, 0);
        expect_out("R10 past sram end", S_NONE, 16'h0, 4'h0, 1'b1);
        idle_cycle();
        expect_out("R10 error lasts one cycle", S_NONE, 16'h0, 4'h0, 1'b0);
        access(32'h0009_0000, 2'd0, 1'b0, 1'b1, 0);
        expect_out("R10 past flash end", S_NONE, 16'h0, 4'h0, 1'b1);
        access(32'h4000_0000, 2'd2, 1'b1, 1'b0, 0);
        expect_out("R10 middle of space", S_NONE, 16'h0, 4'h0, 1'b1);
    endtask

    task automatic t_misalign();
        access(32'h0001_0002, 2'd2, 1'b1, 1'b0, 0);
        expect_out("R9 misaligned word", S_NONE, 16'h0, 4'h0, 1'b1);
        access(32'h0001_0001, 2'd1, 1'b1, 1'b0, 0);
        expect_out("R9 misaligned halfword", S_NONE, 16'h0, 4'h0, 1'b1);
        access(32'h0001_0000, 2'd3, 1'b1, 1'b0, 0);
        expect_out("R9 illegal size", S_NONE, 16'h0, 4'h0, 1'b1);
    endtask

    task automatic t_boot();
        access(32'h0008_F800, 2'd2, 1'b0, 1'b1, 0);
        expect_out("R11 boot write direct", S_NONE, 16'h0, 4'h0, 1'b1);
        access(32'h0008_F7FC, 2'd2, 1'b0, 1'b1, 0);
        expect_out("R11 write below boot page", S_FLASH, 16'hF7FC, 4'hF, 1'b0);
        access(32'h0000_FFFC, 2'd2, 1'b0, 1'b1, 0);
        expect_out("R11 boot write via alias", S_NONE, 16'h0, 4'h0, 1'b1);
    endtask

    task automatic t_remap();
        // Data has bit 0 clear, others set: remap goes to 0
        access(32'hFFFF_0220, 2'd2, 1'b0, 1'b1, 32'hFFFF_FFFE);
        expect_out("R7 remap write selects register block", S_MMR, 16'h0220, 4'hF, 1'b0);
        access(32'h0000_0010, 2'd2, 1'b1, 1'b0, 0);
        expect_out("R6 R7 alias now sram", S_SRAM, 16'h0010, 4'hF, 1'b0);
        access(32'h0000_A004, 2'd2, 1'b1, 1'b0, 0);
        expect_out("R6 sram image repeats", S_SRAM, 16'h0004, 4'hF, 1'b0);
        access(32'h0000_FFFC, 2'd2, 1'b0, 1'b1, 0);
        expect_out("R6 R11 alias write to sram allowed", S_SRAM, 16'h1FFC, 4'hF, 1'b0);
        // Ignored writes: other offset, and byte on lane 1 of the remap word
        access(32'hFFFF_0224, 2'd2, 1'b0, 1'b1, 32'h0000_0001);
        access(32'hFFFF_0221, 2'd0, 1'b0, 1'b1, 32'h0000_0101);
        access(32'h0000_0020, 2'd2, 1'b1, 1'b0, 0);
        expect_out("R7 other writes leave remap", S_SRAM, 16'h0020, 4'hF, 1'b0);
        // Byte write on lane 0 sets remap back to 1
        access(32'hFFFF_0220, 2'd0, 1'b0, 1'b1, 32'h0000_0001);
        access(32'h0000_0020, 2'd2, 1'b1, 1'b0, 0);
        expect_out("R5 R7 alias back to flash", S_FLASH, 16'h0020, 4'hF, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #4000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_sram();
        t_flash_mmr();
        t_unmapped();
        t_misalign();
        t_boot();
        t_remap();
        idle_cycle();
        expect_out("R12 final idle", S_NONE, 16'h0, 4'h0, 1'b0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule